// File: doc/BRIEF.md
# Audio Bit-Clock and Word-Select Generator

This block is the timing source of a master-mode audio serial port. It divides the system clock down to a serial bit clock and produces the left/right word-select line. It also produces three single-cycle strobes, one system-clock cycle ahead of the events they mark, so that a serializer and a deserializer running on the system clock know exactly when to shift or capture a bit and when a channel ends.

A one-bit run control starts and stops generation. A 2-bit field sets how many bit clocks each word-select half lasts. A 3-bit field can gate the bit clock, so that it stops after a fixed count of cycles in each half and restarts with the next half. Both fields are sampled only when generation starts and at each frame boundary. Clearing the run control never cuts a frame short: the current left/right pair completes first.

Top module: `bclk_ws_gen`

## Requirements
- R1: While `clkEn` is 0 and the generator is idle (after reset, or after a stop has completed), `bclk`, `ws`, `bclkRise`, `bclkFall` and `chanStb` all stay 0.
- R2: Each word-select half lasts the number of bit clocks selected by `wordSize`: code 0 gives 16, code 1 gives 24, and code 2 or 3 gives 32. The half therefore lasts that count times 2*DIV_HALF system cycles. After a start the first half is the left one (`ws` = 0).
- R3: With `gateSel` = 0 the bit clock toggles through the whole half, so every half has as many rising edges as its length in bit clocks.
- R4: `gateSel` codes 1, 2, 3 and 4 allow at most 12, 16, 20 and 24 rising edges of `bclk` per half. When the half is shorter than that limit, the half length sets the count instead.
- R5: `gateSel` codes 5, 6 and 7 behave exactly as code 0.
- R6: Once gated, `bclk` stays low for the rest of the half, and it resumes in the next half. Gating does not change the length of the half.
- R7: `ws` changes only at a falling-edge instant of the bit clock, that is one system cycle after `chanStb`.
- R8: While it is running, the bit clock has a period of 2*DIV_HALF system cycles and a 50% duty cycle. `bclkRise` is high in the system cycle just before `bclk` goes high, and `bclkFall` is high in the system cycle just before `bclk` goes low.
- R9: When `clkEn` is cleared, the frame in progress completes, including its right half. After that `ws` and `bclk` stay low until `clkEn` is set again.
- R10: A change of `wordSize` or `gateSel` takes effect at the start of the next frame (the next left half). The half in progress and the right half of the current frame keep the old settings.
- R11: `bclkRise` and `bclkFall` are never high together, and each strobe is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Run control for bit-clock and word-select generation |
| wordSize | input | 2 | Half length select: 0=16, 1=24, 2/3=32 bit clocks |
| gateSel | input | 3 | Gating select: 0 or 5-7 none; 1-4 gate after 12/16/20/24 cycles |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, 0 for the left half and 1 for the right half |
| bclkRise | output | 1 | High for one cycle before bclk rises |
| bclkFall | output | 1 | High for one cycle before bclk falls |
| chanStb | output | 1 | High for one cycle before ws toggles (end of a half) |

## Verification
`clkEn` is sampled at a system clock edge, and generation starts at that same edge. The first `bclkRise` appears DIV_HALF-1 cycles later, and `bclk` goes high one edge after that strobe. `ws` toggles one edge after `chanStb`. A new `wordSize` or `gateSel` shows only in the left half after the next `ws` fall. The bench steps a behavioural reference model at every rising edge, using the same input values the design sees, and compares all five outputs at the following falling edge. This means every one-cycle offset above is checked where it lands. The half-length, gating, period and stop checks count `bclk` rising transitions and cycles between `ws` transitions. Each measurement window opens on an observed `ws` edge, so it always lines up with a whole half.

// File: rtl/bclk_ws_pkg.sv
package bclk_ws_pkg;

  localparam int CNT_W = 6;

  // Strobes and phase level passed from the sequencer to the datapath
  typedef struct packed {
    logic start;    // generation begins at this edge
    logic rise;     // bit clock phase goes high at this edge
    logic fall;     // bit clock phase goes low at this edge
    logic phaseHi;  // current bit clock phase
  } seqStb_t;

  function automatic logic [CNT_W-1:0] halfBits(input logic [1:0] code);
    case (code)
      2'd0:    halfBits = CNT_W'(16);
      2'd1:    halfBits = CNT_W'(24);
      default: halfBits = CNT_W'(32);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] gateBits(input logic [2:0] code);
    case (code)
      3'd1:    gateBits = CNT_W'(12);
      3'd2:    gateBits = CNT_W'(16);
      3'd3:    gateBits = CNT_W'(20);
      3'd4:    gateBits = CNT_W'(24);
      default: gateBits = '0;
    endcase
  endfunction

endpackage

// File: rtl/bclk_ws_seq.sv
module bclk_ws_seq
  import bclk_ws_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clkEn,
  input  logic    frameLast,
  output seqStb_t stb
);

  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  typedef enum logic {S_IDLE, S_RUN} seqState_t;

  seqState_t state;
  logic      phaseHi;
  logic      running;
  logic      tick;

  assign running = (state == S_RUN);

  generate
    if (DIV_HALF == 1) begin : g_nodiv
      assign tick = running;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                divCnt <= '0;
        else if (!running || tick) divCnt <= '0;
        else                       divCnt <= divCnt + 1'b1;
      end
      assign tick = running && (divCnt == DIV_W'(DIV_HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phaseHi <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          phaseHi <= 1'b0;
          if (clkEn) state <= S_RUN;
        end
        default: begin
          if (tick) begin
            phaseHi <= ~phaseHi;
            if (phaseHi && frameLast && !clkEn) state <= S_IDLE;
          end
        end
      endcase
    end
  end

  always_comb begin
    stb.start   = !running && clkEn;
    stb.rise    = tick && !phaseHi;
    stb.fall    = tick && phaseHi;
    stb.phaseHi = phaseHi;
  end

endmodule

// File: rtl/bclk_ws_dp.sv
module bclk_ws_dp
  import bclk_ws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] wordSize,
  input  logic [2:0] gateSel,
  input  seqStb_t    stb,
  output logic       frameLast,
  output logic       bclk,
  output logic       ws,
  output logic       bclkRise,
  output logic       bclkFall,
  output logic       chanStb
);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] gateLen;
  logic             wsQ;
  logic             lastBit;
  logic             gated;

  assign lastBit   = (bitCnt == halfLen - CNT_W'(1));
  assign frameLast = lastBit && wsQ;
  assign gated     = (gateLen != '0) && (bitCnt >= gateLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      wsQ     <= 1'b0;
      halfLen <= halfBits(2'd0);
      gateLen <= '0;
    end else if (stb.start) begin
      bitCnt  <= '0;
      wsQ     <= 1'b0;
      halfLen <= halfBits(wordSize);
      gateLen <= gateBits(gateSel);
    end else if (stb.fall) begin
      if (lastBit) begin
        bitCnt <= '0;
        wsQ    <= ~wsQ;
        if (wsQ) begin
          halfLen <= halfBits(wordSize);
          gateLen <= gateBits(gateSel);
        end
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign bclk     = stb.phaseHi && !gated;
  assign ws       = wsQ;
  assign bclkRise = stb.rise && !gated;
  assign bclkFall = stb.fall && !gated;
  assign chanStb  = stb.fall && lastBit;

endmodule

// File: rtl/bclk_ws_gen.sv
module bclk_ws_gen
  import bclk_ws_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  logic [1:0] wordSize,
  input  logic [2:0] gateSel,
  output logic       bclk,
  output logic       ws,
  output logic       bclkRise,
  output logic       bclkFall,
  output logic       chanStb
);

  seqStb_t stb;
  logic    frameLast;

  bclk_ws_seq #(.DIV_HALF(DIV_HALF)) u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .clkEn     (clkEn),
    .frameLast (frameLast),
    .stb       (stb)
  );

  bclk_ws_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wordSize  (wordSize),
    .gateSel   (gateSel),
    .stb       (stb),
    .frameLast (frameLast),
    .bclk      (bclk),
    .ws        (ws),
    .bclkRise  (bclkRise),
    .bclkFall  (bclkFall),
    .chanStb   (chanStb)
  );

endmodule

// File: rtl/bclk_ws_chk.sv
module bclk_ws_chk (
  input logic clk,
  input logic rstN,
  input logic clkEn,
  input logic bclk,
  input logic ws,
  input logic bclkRise,
  input logic bclkFall,
  input logic chanStb
);

  p_edge_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(bclkRise && bclkFall));

  p_chan_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    chanStb |=> !chanStb);

  p_rise_lead_r8: assert property (@(posedge clk) disable iff (!rstN)
    bclkRise |=> bclk);

  p_fall_lead_r8: assert property (@(posedge clk) disable iff (!rstN)
    bclkFall |=> !bclk);

  p_bclk_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bclk) |-> $past(bclkRise));

  p_ws_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ws) |-> $past(chanStb));

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chanStb && ws && !clkEn) |=> (!ws && !bclk));

endmodule

bind bclk_ws_gen bclk_ws_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEn    (clkEn),
  .bclk     (bclk),
  .ws       (ws),
  .bclkRise (bclkRise),
  .bclkFall (bclkFall),
  .chanStb  (chanStb)
);

// File: tb/sim_bclk_ws_gen.sv
module sim_bclk_ws_gen;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b0;
  logic [1:0] wordSize = 2'd0;
  logic [2:0] gateSel = 3'd0;
  logic       bclk, ws, bclkRise, bclkFall, chanStb;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bclk_ws_gen #(.DIV_HALF(DIV)) u0 (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wordSize(wordSize),
    .gateSel(gateSel), .bclk(bclk), .ws(ws), .bclkRise(bclkRise),
    .bclkFall(bclkFall), .chanStb(chanStb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int halfOf(input int c);
    return (c == 0) ? 16 : (c == 1) ? 24 : 32;
  endfunction

  function automatic int gateOf(input int c);
    return (c >= 1 && c <= 4) ? 8 + 4 * c : 0;
  endfunction

  // Behavioural reference model, stepped at each rising edge
  int mRun = 0, mSub = 0, mHi = 0, mBit = 0, mWs = 0, mHalf = 16, mGate = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mSub = 0; mHi = 0; mBit = 0; mWs = 0; mHalf = 16; mGate = 0;
    end else if (mRun == 0) begin
      if (clkEn) begin
        mRun = 1; mSub = 0; mHi = 0; mBit = 0; mWs = 0;
        mHalf = halfOf(int'(wordSize)); mGate = gateOf(int'(gateSel));
      end
    end else if (mSub == DIV - 1) begin
      mSub = 0;
      if (mHi == 0) mHi = 1;
      else begin
        mHi = 0;
        if (mBit == mHalf - 1) begin
          mBit = 0;
          if (mWs == 1) begin
            mWs = 0;
            if (!clkEn) mRun = 0;
            else begin
              mHalf = halfOf(int'(wordSize)); mGate = gateOf(int'(gateSel));
            end
          end else mWs = 1;
        end else mBit++;
      end
    end else mSub++;
  end

  // Cycle compare against the model (R7 ws timing, R8 edges, R11 strobes)
  always @(negedge clk) begin
    if (rstN) begin
      automatic int gatedM = (mGate != 0 && mBit >= mGate) ? 1 : 0;
      automatic int tickM  = (mRun == 1 && mSub == DIV - 1) ? 1 : 0;
      chk("R8 bclk cycle compare", int'(bclk), (mRun == 1 && mHi == 1 && gatedM == 0) ? 1 : 0);
      chk("R7 ws cycle compare", int'(ws), mWs);
      chk("R11 rise strobe compare", int'(bclkRise), (tickM == 1 && mHi == 0 && gatedM == 0) ? 1 : 0);
      chk("R11 fall strobe compare", int'(bclkFall), (tickM == 1 && mHi == 1 && gatedM == 0) ? 1 : 0);
      chk("R11 channel strobe compare", int'(chanStb), (tickM == 1 && mHi == 1 && mBit == mHalf - 1) ? 1 : 0);
    end
  end

  // Counts bclk rises and cycles over the next whole half at the given ws level
  task automatic measureHalf(input logic level, output int rises, output int cycles);
    logic prev;
    rises = 0; cycles = 0;
    @(negedge clk);
    while (ws == level) @(negedge clk);
    while (ws != level) @(negedge clk);
    prev = bclk;
    while (ws == level) begin
      if (bclk && !prev) rises++;
      prev = bclk;
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic quietWindow(input int n, output int rises, output int wsHigh);
    logic prev;
    rises = 0; wsHigh = 0;
    prev = bclk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bclk && !prev) rises++;
      if (ws) wsHigh++;
      prev = bclk;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int r, c, t0, t1;
    logic prev;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1 reset bclk", int'(bclk), 0);
    chk("R1 reset ws", int'(ws), 0);
    chk("R1 reset strobes", int'(bclkRise) + int'(bclkFall) + int'(chanStb), 0);
    quietWindow(40, r, c);
    chk("R1 idle rises", r, 0);
    chk("R1 idle ws", c, 0);

    // R2/R3: 16-bit halves, no gating
    clkEn = 1'b1;
    measureHalf(1'b1, r, c);
    chk("R2 half16 right rises", r, 16);
    chk("R2 half16 right cycles", c, 16 * 2 * DIV);
    measureHalf(1'b0, r, c);
    chk("R3 half16 left rises", r, 16);
    chk("R2 half16 left cycles", c, 16 * 2 * DIV);

    // R8: bit-clock period
    @(negedge clk);
    prev = bclk;
    t0 = -1; t1 = -1;
    for (int i = 0; i < 6 * DIV && t1 < 0; i++) begin
      @(negedge clk);
      if (bclk && !prev) begin
        if (t0 < 0) t0 = i; else t1 = i;
      end
      prev = bclk;
    end
    chk("R8 bclk period", t1 - t0, 2 * DIV);

    // R10: change mid left half, right half of this frame keeps old length
    while (ws) @(negedge clk);
    repeat (20) @(negedge clk);
    wordSize = 2'd2;
    measureHalf(1'b1, r, c);
    chk("R10 right half old length", r, 16);
    measureHalf(1'b0, r, c);
    chk("R10 next left new length", r, 32);
    measureHalf(1'b1, r, c);
    chk("R2 half32 right rises", r, 32);

    wordSize = 2'd1;
    measureHalf(1'b0, r, c);
    chk("R2 half24 left rises", r, 24);
    chk("R2 half24 cycles", c, 24 * 2 * DIV);
    wordSize = 2'd3;
    measureHalf(1'b0, r, c);
    chk("R2 code3 half rises", r, 32);

    // R4/R6: gating within 32-bit halves
    wordSize = 2'd2;
    for (int g = 1; g <= 4; g++) begin
      gateSel = 3'(g);
      measureHalf(1'b0, r, c);
      chk($sformatf("R4 gate code %0d left rises", g), r, 8 + 4 * g);
      chk("R6 gated half length", c, 32 * 2 * DIV);
      measureHalf(1'b1, r, c);
      chk($sformatf("R6 gate code %0d resumes right", g), r, 8 + 4 * g);
    end

    // R4: gate longer than half
    wordSize = 2'd0;
    gateSel = 3'd4;
    measureHalf(1'b0, r, c);
    chk("R4 gate24 in half16", r, 16);

    // R5: reserved gate codes
    wordSize = 2'd2;
    for (int g = 5; g <= 7; g++) begin
      gateSel = 3'(g);
      measureHalf(1'b0, r, c);
      chk($sformatf("R5 gate code %0d rises", g), r, 32);
    end

    // R9: stop in left half finishes frame then goes quiet
    wordSize = 2'd0;
    gateSel = 3'd0;
    measureHalf(1'b0, r, c);
    while (ws) @(negedge clk);
    repeat (10) @(negedge clk);
    clkEn = 1'b0;
    measureHalf(1'b1, r, c);
    chk("R9 right half completes", r, 16);
    quietWindow(200, r, c);
    chk("R9 no bclk after stop", r, 0);
    chk("R9 ws held low", c, 0);

    // R1: restart after stop
    clkEn = 1'b1;
    measureHalf(1'b1, r, c);
    chk("R1 restart right rises", r, 16);

    clkEn = 1'b0;
    repeat (300) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule